// File: doc/BRIEF.md
# Priority Interrupt Level Evaluator

This block decides which pending interrupt the processor takes next. Each source has a fixed priority level. A source counts as pending only if its level is strictly above the processor's current 5-bit level. The one exception is the halt pin, which always wins. The sources are:

- the halt pin;
- a memory-error request, a corrected-data request and an interval-clock request;
- four device levels, each with sixteen requesting slots;
- a console receive and a console transmit request;
- a 15-bit software request summary.

The block holds each pulsed hardware request until that request is acknowledged. The chosen level is produced combinationally. The processor then acknowledges that level. In the same cycle the block returns the vector for the source being serviced. On the next clock edge it clears the request it serviced.

Device vectors are not held in a table. Each one is computed from the device level and the slot. Only the lowest-numbered requesting slot of a level is serviced by one acknowledge, so the others stay pending. The vector-table memory itself is outside this block.

Top module: `intpri_eval`

## Requirements
- R1: After reset every held request is clear, so with `haltPin` low and `swReq` zero, `pendLevel` reads 0 at any `curLevel`.
- R2: While `haltPin` is high, `pendLevel` is 0x1F whatever `curLevel` and the other requests are.
- R3: A pulse on `memErrReq`, `crdErrReq` or `clockReq` is held until it is acknowledged. These sources take levels 0x1D, 0x1A and 0x18, in that priority order. Each one is reported only if its level exceeds `curLevel`.
- R4: A pulse on bit (L-0x14)*16+S of `devReq` holds a request at device level L (0x14..0x17), slot S. Device levels are examined from 0x17 downward. The first level that is not above `curLevel` ends the search with result 0, and the console and software sources are not examined.
- R5: A held console receive or transmit request gives level 0x14. It is considered only after the device levels and only when 0x14 exceeds `curLevel`.
- R6: Bit k of `swReq` (k = 1..15) requests level k. The highest set bit strictly above `curLevel` is reported. No software level is reported when `curLevel` is 15 or more. The block never alters `swReq`.
- R7: `pendLevel` is combinational from `curLevel` and the requests, and is 0 when nothing qualifies.
- R8: An acknowledge at a device level L with any slot held returns `DEV_BASE + (L-0x14)*0x40 + S*4`, where S is the lowest held slot. That slot alone clears on the next edge.
- R9: An acknowledge at 0x14 with no device slot held at 0x14 returns `RX_VEC` and clears receive if receive is held. Otherwise it returns `TX_VEC` and clears transmit if transmit is held. Otherwise it returns 0.
- R10: An acknowledge at 0x1D, 0x1A or 0x18 returns `MEM_VEC`, `CRD_VEC` or `CLK_VEC` respectively, and clears that request on the next edge.
- R11: An acknowledge at any other level above 0x17 sets `ackError` and returns vector 0. An acknowledge below 0x14 returns 0 with no error and clears nothing. Without `ackValid`, both outputs are 0.
- R12: When a set pulse and an acknowledge-clear hit the same request in one cycle, the request stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| curLevel | input | 5 | Current processor priority level |
| haltPin | input | 1 | Halt request, level sensitive |
| memErrReq | input | 1 | Memory-error set pulse |
| crdErrReq | input | 1 | Corrected-data set pulse |
| clockReq | input | 1 | Interval-clock set pulse |
| devReq | input | 64 | Device slot set pulses, bit (L-0x14)*16+S |
| conRxReq | input | 1 | Console receive set pulse |
| conTxReq | input | 1 | Console transmit set pulse |
| swReq | input | 15 | Software request summary, bits 15:1 |
| ackValid | input | 1 | Acknowledge strobe |
| ackLevel | input | 5 | Level being acknowledged |
| pendLevel | output | 5 | Highest qualifying level, 0 if none |
| ackVector | output | 16 | Vector for the acknowledged source |
| ackError | output | 1 | Acknowledge at an unserviceable high level |

## Verification
The hardest situation to reach is a set pulse arriving on the very slot that an acknowledge is clearing. The same is true of an acknowledge landing while several slots of one level are held, so that only the lowest one may drop. The stimulus builds these states on purpose by loading two slots of one level and then acknowledging while re-pulsing a slot. A long random phase follows. It sweeps `curLevel` across all 32 values and mixes sparse pulses with acknowledges at every level, including those that must raise the error flag. The behavioural model in the bench tracks held requests and predicts the level and vector every cycle.

// File: rtl/intpri_pkg.sv
package intpri_pkg;
  localparam int NUM_DEV_LVL = 4;
  localparam int NUM_SLOTS   = 16;
  localparam int DEV_LVL_W   = $clog2(NUM_DEV_LVL);
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int LVL_W       = 5;
  localparam int SW_TOP      = 15;

  localparam logic [LVL_W-1:0] LVL_HALT   = 5'h1F;
  localparam logic [LVL_W-1:0] LVL_MEM    = 5'h1D;
  localparam logic [LVL_W-1:0] LVL_CRD    = 5'h1A;
  localparam logic [LVL_W-1:0] LVL_CLK    = 5'h18;
  localparam logic [LVL_W-1:0] LVL_DEV_LO = 5'h14;
  localparam logic [LVL_W-1:0] LVL_DEV_HI = 5'h17;
  localparam logic [LVL_W-1:0] LVL_CON    = 5'h14;

  typedef logic [NUM_DEV_LVL-1:0][NUM_SLOTS-1:0] devVec_t;

  typedef struct packed {
    logic                 clrMem;
    logic                 clrCrd;
    logic                 clrClk;
    logic                 clrDev;
    logic [DEV_LVL_W-1:0] devLvl;
    logic [SLOT_W-1:0]    devSlot;
    logic                 clrRx;
    logic                 clrTx;
  } clrStrobe_t;
endpackage

// File: rtl/intpri_dp.sv
module intpri_dp
  import intpri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       memSet,
  input  logic       crdSet,
  input  logic       clkSet,
  input  devVec_t    devSet,
  input  logic       rxSet,
  input  logic       txSet,
  input  clrStrobe_t strb,
  output logic       memPend,
  output logic       crdPend,
  output logic       clkPend,
  output devVec_t    devPend,
  output logic       rxPend,
  output logic       txPend
);
  devVec_t devClr;

  generate
    for (genvar l = 0; l < NUM_DEV_LVL; l++) begin : g_lvl
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign devClr[l][s] = strb.clrDev && (strb.devLvl == DEV_LVL_W'(l))
                              && (strb.devSlot == SLOT_W'(s));
      end
    end
  endgenerate

  // set wins over clear (R12)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memPend <= 1'b0;
      crdPend <= 1'b0;
      clkPend <= 1'b0;
      devPend <= '0;
      rxPend  <= 1'b0;
      txPend  <= 1'b0;
    end else begin
      memPend <= memSet | (memPend & ~strb.clrMem);
      crdPend <= crdSet | (crdPend & ~strb.clrCrd);
      clkPend <= clkSet | (clkPend & ~strb.clrClk);
      devPend <= devSet | (devPend & ~devClr);
      rxPend  <= rxSet  | (rxPend  & ~strb.clrRx);
      txPend  <= txSet  | (txPend  & ~strb.clrTx);
    end
  end

  a_r8_one_slot_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrDev && devSet == '0) |=> $countones(devPend) == $countones($past(devPend)) - 1);
  a_r8_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrDev |=> (($past(devPend) & ~devPend) == '0));
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (devSet != '0) |=> ((devPend & $past(devSet)) == $past(devSet)));
  a_r10_mem_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrMem && !memSet) |=> !memPend);
endmodule

// File: rtl/intpri_ctrl.sv
module intpri_ctrl
  import intpri_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int MEM_VEC  = 'h60,
  parameter int CRD_VEC  = 'h54,
  parameter int CLK_VEC  = 'hC0,
  parameter int RX_VEC   = 'hF8,
  parameter int TX_VEC   = 'hFC,
  parameter int DEV_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  curLevel,
  input  logic              haltPin,
  input  logic [SW_TOP:1]   swReq,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic              memPend,
  input  logic              crdPend,
  input  logic              clkPend,
  input  devVec_t           devPend,
  input  logic              rxPend,
  input  logic              txPend,
  output logic [LVL_W-1:0]  pendLevel,
  output logic [VEC_W-1:0]  ackVector,
  output logic              ackError,
  output clrStrobe_t        strb
);
  localparam int LVL_STRIDE = NUM_SLOTS * 4;

  logic                 scanHit, scanStop;
  logic [LVL_W-1:0]     scanLvl;
  logic [DEV_LVL_W-1:0] ackIdx;
  logic [SLOT_W-1:0]    lowSlot;
  logic                 slotHit;

  // priority evaluation
  always_comb begin
    pendLevel = '0;
    scanHit   = 1'b0;
    scanStop  = 1'b0;
    scanLvl   = '0;
    if (haltPin) pendLevel = LVL_HALT;
    else if (curLevel < LVL_MEM && memPend) pendLevel = LVL_MEM;
    else if (curLevel < LVL_CRD && crdPend) pendLevel = LVL_CRD;
    else if (curLevel < LVL_CLK && clkPend) pendLevel = LVL_CLK;
    else begin
      for (int k = NUM_DEV_LVL - 1; k >= 0; k--) begin
        scanLvl = LVL_DEV_LO + LVL_W'(k);
        if (!scanHit && !scanStop) begin
          if (scanLvl <= curLevel) scanStop = 1'b1;
          else if (|devPend[k]) begin
            scanHit   = 1'b1;
            pendLevel = scanLvl;
          end
        end
      end
      if (!scanHit && !scanStop) begin
        if (curLevel < LVL_CON && (rxPend || txPend)) pendLevel = LVL_CON;
        else if (curLevel < LVL_W'(SW_TOP)) begin
          for (int j = SW_TOP; j >= 1; j--) begin
            if (!scanHit && swReq[j] && LVL_W'(j) > curLevel) begin
              scanHit   = 1'b1;
              pendLevel = LVL_W'(j);
            end
          end
        end
      end
    end
  end

  // acknowledge decode
  always_comb begin
    ackIdx  = DEV_LVL_W'(ackLevel - LVL_DEV_LO);
    lowSlot = '0;
    slotHit = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (devPend[ackIdx][s]) begin
        lowSlot = SLOT_W'(s);
        slotHit = 1'b1;
      end
    end
  end

  always_comb begin
    strb      = '0;
    ackVector = '0;
    ackError  = 1'b0;
    if (ackValid) begin
      if (ackLevel == LVL_MEM) begin
        ackVector   = VEC_W'(MEM_VEC);
        strb.clrMem = 1'b1;
      end else if (ackLevel == LVL_CRD) begin
        ackVector   = VEC_W'(CRD_VEC);
        strb.clrCrd = 1'b1;
      end else if (ackLevel == LVL_CLK) begin
        ackVector   = VEC_W'(CLK_VEC);
        strb.clrClk = 1'b1;
      end else if (ackLevel > LVL_DEV_HI) begin
        ackError = 1'b1;
      end else if (ackLevel >= LVL_DEV_LO) begin
        if (slotHit) begin
          ackVector    = VEC_W'(DEV_BASE) + VEC_W'(ackIdx) * VEC_W'(LVL_STRIDE)
                         + (VEC_W'(lowSlot) << 2);
          strb.clrDev  = 1'b1;
          strb.devLvl  = ackIdx;
          strb.devSlot = lowSlot;
        end else if (ackLevel == LVL_CON) begin
          if (rxPend) begin
            ackVector  = VEC_W'(RX_VEC);
            strb.clrRx = 1'b1;
          end else if (txPend) begin
            ackVector  = VEC_W'(TX_VEC);
            strb.clrTx = 1'b1;
          end
        end
      end
    end
  end

  a_r11_error_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ackError |-> (ackVector == '0 && ackValid));
  a_r7_above_current: assert property (@(posedge clk) disable iff (!rst_n)
    (pendLevel != '0 && !haltPin) |-> pendLevel > curLevel);
  a_r9_rx_before_tx: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrTx |-> !rxPend);
  a_r6_sw_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (pendLevel != '0 && pendLevel <= LVL_W'(SW_TOP)) |-> curLevel < LVL_W'(SW_TOP));
  a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.clrMem, strb.clrCrd, strb.clrClk, strb.clrDev, strb.clrRx, strb.clrTx}));
endmodule

// File: rtl/intpri_eval.sv
module intpri_eval
  import intpri_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int MEM_VEC  = 'h60,
  parameter int CRD_VEC  = 'h54,
  parameter int CLK_VEC  = 'hC0,
  parameter int RX_VEC   = 'hF8,
  parameter int TX_VEC   = 'hFC,
  parameter int DEV_BASE = 'h100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LVL_W-1:0]                 curLevel,
  input  logic                             haltPin,
  input  logic                             memErrReq,
  input  logic                             crdErrReq,
  input  logic                             clockReq,
  input  logic [NUM_DEV_LVL*NUM_SLOTS-1:0] devReq,
  input  logic                             conRxReq,
  input  logic                             conTxReq,
  input  logic [SW_TOP:1]                  swReq,
  input  logic                             ackValid,
  input  logic [LVL_W-1:0]                 ackLevel,
  output logic [LVL_W-1:0]                 pendLevel,
  output logic [VEC_W-1:0]                 ackVector,
  output logic                             ackError
);
  devVec_t    devSetV, devPend;
  clrStrobe_t strb;
  logic       memPend, crdPend, clkPend, rxPend, txPend;

  assign devSetV = devReq;

  intpri_dp u_dp (
    .clk(clk), .rst_n(rst_n),
    .memSet(memErrReq), .crdSet(crdErrReq), .clkSet(clockReq),
    .devSet(devSetV), .rxSet(conRxReq), .txSet(conTxReq), .strb(strb),
    .memPend(memPend), .crdPend(crdPend), .clkPend(clkPend),
    .devPend(devPend), .rxPend(rxPend), .txPend(txPend)
  );

  intpri_ctrl #(
    .VEC_W(VEC_W), .MEM_VEC(MEM_VEC), .CRD_VEC(CRD_VEC), .CLK_VEC(CLK_VEC),
    .RX_VEC(RX_VEC), .TX_VEC(TX_VEC), .DEV_BASE(DEV_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .curLevel(curLevel), .haltPin(haltPin),
    .swReq(swReq), .ackValid(ackValid), .ackLevel(ackLevel),
    .memPend(memPend), .crdPend(crdPend), .clkPend(clkPend),
    .devPend(devPend), .rxPend(rxPend), .txPend(txPend),
    .pendLevel(pendLevel), .ackVector(ackVector), .ackError(ackError),
    .strb(strb)
  );
endmodule

// File: tb/intpri_eval_test.sv
module intpri_eval_test;
  localparam int V_MEM = 'h60, V_CRD = 'h54, V_CLK = 'hC0;
  localparam int V_RX = 'hF8, V_TX = 'hFC, V_DEV = 'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  curLevel;
  logic        haltPin, memErrReq, crdErrReq, clockReq, conRxReq, conTxReq;
  logic [63:0] devReq;
  logic [15:1] swReq;
  logic        ackValid;
  logic [4:0]  ackLevel;
  logic [4:0]  pendLevel;
  logic [15:0] ackVector;
  logic        ackError;

  always #5 clk = ~clk;

  intpri_eval uut (
    .clk(clk), .rst_n(rst_n), .curLevel(curLevel), .haltPin(haltPin),
    .memErrReq(memErrReq), .crdErrReq(crdErrReq), .clockReq(clockReq),
    .devReq(devReq), .conRxReq(conRxReq), .conTxReq(conTxReq), .swReq(swReq),
    .ackValid(ackValid), .ackLevel(ackLevel),
    .pendLevel(pendLevel), .ackVector(ackVector), .ackError(ackError)
  );

  // reference state
  bit        mM, cM, kM, rxM, txM;
  bit [15:0] dM [4];
  // planned clears for the coming edge
  bit        cuM, cuC, cuK, cuRx, cuTx, cuDev;
  int        cuL, cuS;
  int        expVec;
  bit        expErr;
  int        nChecks = 0, nFails = 0;
  string     forceTag = "";
  bit        done = 0;

  function automatic int expPend();
    if (haltPin) return 31;
    for (int lv = 31; lv > int'(curLevel); lv--) begin
      if (lv == 29 && mM) return lv;
      if (lv == 26 && cM) return lv;
      if (lv == 24 && kM) return lv;
      if (lv >= 20 && lv <= 23 && dM[lv-20] != 0) return lv;
      if (lv == 20 && (rxM || txM)) return lv;
      if (lv >= 1 && lv <= 15 && swReq[lv]) return lv;
    end
    return 0;
  endfunction

  function automatic string pendTag(int lv);
    if (forceTag != "") return forceTag;
    if (lv == 31) return "R2";
    if (lv >= 24) return "R3";
    if (lv >= 21) return "R4";
    if (lv == 20) return (dM[0] != 0) ? "R4" : "R5";
    if (lv >= 1) return "R6";
    return "R7";
  endfunction

  task automatic planAck(output string tag);
    int lv = int'(ackLevel);
    expVec = 0; expErr = 0; tag = "R11";
    {cuM, cuC, cuK, cuRx, cuTx, cuDev} = '0;
    if (!ackValid) return;
    if (lv == 29) begin expVec = V_MEM; cuM = 1; tag = "R10"; end
    else if (lv == 26) begin expVec = V_CRD; cuC = 1; tag = "R10"; end
    else if (lv == 24) begin expVec = V_CLK; cuK = 1; tag = "R10"; end
    else if (lv > 23) expErr = 1;
    else if (lv >= 20) begin
      tag = "R8";
      for (int s = 15; s >= 0; s--)
        if (dM[lv-20][s]) begin cuDev = 1; cuL = lv - 20; cuS = s; end
      if (cuDev) expVec = V_DEV + cuL * 64 + cuS * 4;
      else if (lv == 20) begin
        tag = "R9";
        if (rxM) begin expVec = V_RX; cuRx = 1; end
        else if (txM) begin expVec = V_TX; cuTx = 1; end
      end
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    string at;
    int ep;
    #1;
    ep = expPend();
    check(pendTag(ep), "pendLevel", int'(pendLevel), ep);
    planAck(at);
    if (ackValid) begin
      check(at, "ackVector", int'(ackVector), expVec);
      check(at, "ackError", int'(ackError), int'(expErr));
    end
    @(posedge clk);
    if (cuM) mM = 0;
    if (cuC) cM = 0;
    if (cuK) kM = 0;
    if (cuRx) rxM = 0;
    if (cuTx) txM = 0;
    if (cuDev) dM[cuL][cuS] = 0;
    if (memErrReq) mM = 1;
    if (crdErrReq) cM = 1;
    if (clockReq) kM = 1;
    if (conRxReq) rxM = 1;
    if (conTxReq) txM = 1;
    for (int b = 0; b < 64; b++) if (devReq[b]) dM[b/16][b%16] = 1;
    @(negedge clk);
    {memErrReq, crdErrReq, clockReq, conRxReq, conTxReq, ackValid} = '0;
    devReq = '0;
  endtask

  task automatic ack(int lv);
    ackValid = 1; ackLevel = 5'(lv); step();
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst_n = 0; curLevel = 0; haltPin = 0; swReq = '0; ackValid = 0; ackLevel = 0;
    {memErrReq, crdErrReq, clockReq, conRxReq, conTxReq} = '0;
    devReq = '0;
    for (int i = 0; i < 4; i++) dM[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    forceTag = "R1";
    step(); curLevel = 5'd3; step();
    forceTag = "";
    // R2 halt at top level
    haltPin = 1; curLevel = 5'h1F; memErrReq = 1; step(); step();
    haltPin = 0; curLevel = 0;
    // R3 fixed sources and order
    crdErrReq = 1; clockReq = 1; step();
    step();
    curLevel = 5'h1D; step();
    curLevel = 5'h1A; step();
    curLevel = 5'h18; step();
    curLevel = 0;
    ack(29); step(); ack(26); step(); ack(24); step();
    // R4 device scan with console and software present
    devReq[2*16+5] = 1; devReq[2*16+9] = 1; devReq[0] = 1;
    conRxReq = 1; conTxReq = 1; swReq = 15'h7FFF; step();
    step();
    curLevel = 5'h16; step();
    curLevel = 5'h15; step();
    curLevel = 5'h14; step();
    curLevel = 0;
    // R8 lowest slot first
    ack(22); step(); ack(22); step(); ack(22);
    // R9 console after device slot at 0x14
    ack(20); step(); ack(20); step(); ack(20); step(); ack(20);
    // R6 software
    swReq = '0; swReq[15] = 1; swReq[1] = 1; step();
    curLevel = 5'd14; step();
    curLevel = 5'd15; step();
    swReq = '0; swReq[3] = 1; curLevel = 5'd2; step();
    curLevel = 5'd3; step();
    swReq = '0; curLevel = 0;
    // R11 error and low-level acks
    ack(31); ack(25); ack(27); ack(5); ack(0);
    // R12 set and clear of one slot in one cycle
    devReq[3*16+3] = 1; step();
    ackValid = 1; ackLevel = 5'h17; devReq[3*16+3] = 1; step();
    forceTag = "R12"; step(); forceTag = "";
    ack(23); step();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      curLevel  = 5'($urandom_range(0, 31));
      haltPin   = ($urandom_range(0, 40) == 0);
      memErrReq = ($urandom_range(0, 12) == 0);
      crdErrReq = ($urandom_range(0, 12) == 0);
      clockReq  = ($urandom_range(0, 10) == 0);
      conRxReq  = ($urandom_range(0, 10) == 0);
      conTxReq  = ($urandom_range(0, 10) == 0);
      for (int b = 0; b < 64; b++) devReq[b] = ($urandom_range(0, 90) == 0);
      if ($urandom_range(0, 7) == 0) swReq = 15'($urandom());
      ackValid = ($urandom_range(0, 2) == 0);
      ackLevel = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(20, 23))
                                              : 5'($urandom_range(0, 31));
      step();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule